// File: doc/BRIEF.md
# Mesh Remote-Store Tile Router

This block sits in each tile of a two-dimensional mesh and moves remote-store packets. A remote store carries one data word, a byte mask, a word address and the coordinates of a destination tile. When the packet reaches that tile, the word is written into the tile's data memory. The router has four link ports (north, south, east and west) and a local port. On the local port the tile core injects packets, and a word-write interface into a 4 KB data memory takes them out. Every input and every link output uses a valid/ready handshake. A packet moves only on a cycle where both valid and ready are high.

Each input has a small FIFO. A route stage looks at the packet at the head of each FIFO and picks one output. X is resolved fully before Y, so the mesh cannot deadlock and needs no extra resources to prevent it. Each output has its own round-robin arbiter that chooses among the inputs competing for it. Input/output endpoints sit on one extra row just past the compute array. They are reached with the same packet format, because the Y comparison is a plain magnitude compare with no special cases. The tile's coordinates come from strap pins and are captured once after reset, so every tile uses the same RTL.

Top module: `mesh_store_router`

## Requirements
- R1: A packet is 80 bits: opcode [79:76], byte mask [75:72], destination X [71:67], destination Y [66:62], word address [61:32], data [31:0]. Opcode 4'h1 is a store. Any other opcode is discarded at the input head without reaching an output, and it sets `err_flag` from the next clock edge on. Only reset clears `err_flag`.
- R2: If the destination X is greater than the tile's X, the packet leaves east (output index 2). If it is smaller, the packet leaves west (index 3). The destination Y does not matter in either case.
- R3: If the destination X equals the tile's X, a larger destination Y leaves south (index 1) and a smaller one leaves north (index 0). A Y one past the compute rows needs no special handling.
- R4: A packet whose destination equals the tile's coordinates raises `mem_we` in the cycle it wins the local output. In that same cycle `mem_addr` carries the low 10 bits of the word address, `mem_wdata` the data and `mem_be` the byte mask.
- R5: Each input holds 2 packets. Its ready is low while both entries are full. A packet is accepted only on an edge where valid and ready are both high.
- R6: Input indices are north 0, south 1, east 2, west 3, local 4. Each output serves competing inputs round-robin, starting just after the last input it served. After reset, input 0 has first priority.
- R7: Packets from one input to one output leave in the order they arrived.
- R8: The tile coordinates are taken from `my_x`/`my_y` on the first clock edge after reset is released. Every input's ready stays low until then. Later changes on those pins have no effect on routing.
- R9: Once a link output raises valid, valid and data stay unchanged until ready is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_x | input | 5 | Tile X coordinate strap |
| my_y | input | 5 | Tile Y coordinate strap |
| in_valid | input | 5 | Per-input packet valid (N,S,E,W,local) |
| in_ready | output | 5 | Per-input ready |
| in_data | input | 5x80 | Per-input packet |
| out_valid | output | 4 | Link output valid (N,S,E,W) |
| out_ready | input | 4 | Link output ready |
| out_data | output | 4x80 | Link output packet |
| mem_we | output | 1 | Data-memory word write enable |
| mem_addr | output | 10 | Data-memory word address |
| mem_wdata | output | 32 | Data-memory write data |
| mem_be | output | 4 | Data-memory byte enables |
| err_flag | output | 1 | Sticky bad-opcode flag |

## Verification
A local memory write and the discard of a bad-opcode packet can happen in the same cycle, because both take a FIFO head out on one edge. The bench makes this happen by presenting a bad-opcode packet on the north input and a local store on the west input on the same edge. It then requires that the memory write appears with the west packet's fields in the next cycle, that no link output becomes valid, and that the error flag rises only after the following edge. Round-robin fairness gets a similar treatment: the bench loads the same output from two inputs while that output is stalled, then releases it and checks that the inputs alternate.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int COORD_W  = 5;
  localparam int WADDR_W  = 30;
  localparam int DATA_W   = 32;
  localparam int BE_W     = DATA_W / 8;
  localparam int OP_W     = 4;
  localparam int PKT_W    = OP_W + BE_W + 2 * COORD_W + WADDR_W + DATA_W;
  localparam int DY_LSB   = WADDR_W + DATA_W;
  localparam int DX_LSB   = DY_LSB + COORD_W;
  localparam int NUM_IN   = 5;
  localparam int NUM_LINK = 4;
  localparam int PIDX_W   = $clog2(NUM_IN);
  localparam int LOC_IDX  = 4;

  localparam logic [OP_W-1:0] OP_STORE = 4'h1;

  localparam logic [PIDX_W-1:0] DIR_N = 3'd0;
  localparam logic [PIDX_W-1:0] DIR_S = 3'd1;
  localparam logic [PIDX_W-1:0] DIR_E = 3'd2;
  localparam logic [PIDX_W-1:0] DIR_W = 3'd3;
  localparam logic [PIDX_W-1:0] DIR_L = 3'd4;

  typedef struct packed {
    logic [OP_W-1:0]    op;
    logic [BE_W-1:0]    be;
    logic [COORD_W-1:0] dx;
    logic [COORD_W-1:0] dy;
    logic [WADDR_W-1:0] waddr;
    logic [DATA_W-1:0]  data;
  } pkt_t;
endpackage

// File: rtl/msr_in_fifo.sv
module msr_in_fifo #(
  parameter int W     = 80,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         not_empty,
  output logic         has_room
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][W-1:0] slot_q;
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    wr_d  = push ? bump(wr_q) : wr_q;
    rd_d  = pop  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot_q[wr_q] <= din;
  end

  assign dout      = slot_q[rd_q];
  assign not_empty = (cnt_q != '0);
  assign has_room  = (cnt_q != CW'(DEPTH));
endmodule

// File: rtl/msr_route.sv
module msr_route
  import msr_pkg::*;
(
  input  pkt_t                head,
  input  logic [COORD_W-1:0]  cx,
  input  logic [COORD_W-1:0]  cy,
  output logic [PIDX_W-1:0]   dir,
  output logic                legal
);
  always_comb begin
    legal = (head.op == OP_STORE);
    if (head.dx > cx)      dir = DIR_E;
    else if (head.dx < cx) dir = DIR_W;
    else if (head.dy > cy) dir = DIR_S;
    else if (head.dy < cy) dir = DIR_N;
    else                   dir = DIR_L;
  end
endmodule

// File: rtl/msr_rr_arb.sv
module msr_rr_arb #(
  parameter int N = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N-1:0]           req,
  input  logic                   ready,
  output logic                   valid,
  output logic [$clog2(N)-1:0]   gidx,
  output logic                   xfer
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] last_q, last_d;
  logic [IW-1:0] gnt_q, gnt_d;
  logic          lock_q, lock_d;
  logic [IW-1:0] pick;
  logic          found;

  function automatic logic [IW:0] rr_pick(input logic [N-1:0] r,
                                          input logic [IW-1:0] last);
    logic          hit;
    logic [IW-1:0] idx;
    int            c;
    hit = 1'b0;
    idx = last;
    for (int k = 1; k <= N; k++) begin
      c = (int'(last) + k) % N;
      if (!hit && r[c]) begin
        hit = 1'b1;
        idx = IW'(c);
      end
    end
    return {hit, idx};
  endfunction

  always_comb begin
    {found, pick} = rr_pick(req, last_q);
    gidx   = lock_q ? gnt_q : pick;
    valid  = |req;
    xfer   = valid & ready;
    lock_d = valid & ~ready;
    gnt_d  = gidx;
    last_d = xfer ? gidx : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= IW'(N - 1);
      gnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      last_q <= last_d;
      gnt_q  <= gnt_d;
      lock_q <= lock_d;
    end
  end
endmodule

// File: rtl/mesh_store_router.sv
module mesh_store_router
  import msr_pkg::*;
#(
  parameter int FIFO_DEPTH = 2,
  parameter int MEM_BYTES  = 4096
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [COORD_W-1:0]                my_x,
  input  logic [COORD_W-1:0]                my_y,
  input  logic [NUM_IN-1:0]                 in_valid,
  output logic [NUM_IN-1:0]                 in_ready,
  input  logic [NUM_IN-1:0][PKT_W-1:0]      in_data,
  output logic [NUM_LINK-1:0]               out_valid,
  input  logic [NUM_LINK-1:0]               out_ready,
  output logic [NUM_LINK-1:0][PKT_W-1:0]    out_data,
  output logic                              mem_we,
  output logic [$clog2(MEM_BYTES/BE_W)-1:0] mem_addr,
  output logic [DATA_W-1:0]                 mem_wdata,
  output logic [BE_W-1:0]                   mem_be,
  output logic                              err_flag
);
  localparam int MEM_AW = $clog2(MEM_BYTES / BE_W);

  // tile coordinate capture and sticky error
  logic               cap_q, cap_d;
  logic [COORD_W-1:0] cx_q, cx_d, cy_q, cy_d;
  logic               err_q, err_d;

  pkt_t [NUM_IN-1:0]              head;
  logic [NUM_IN-1:0]              hv, room, push, pop, legal, drop;
  logic [NUM_IN-1:0][PIDX_W-1:0]  dir;
  logic [NUM_IN-1:0][NUM_IN-1:0]  req;   // req[output][input]
  logic [NUM_IN-1:0]              ovalid, oxfer, ordy;
  logic [NUM_IN-1:0][PIDX_W-1:0]  gidx;
  pkt_t [NUM_IN-1:0]              sel;

  // input side: buffering and route
  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    msr_in_fifo #(.W(PKT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push[i]),
      .din       (in_data[i]),
      .pop       (pop[i]),
      .dout      (head[i]),
      .not_empty (hv[i]),
      .has_room  (room[i])
    );

    msr_route u_route (
      .head  (head[i]),
      .cx    (cx_q),
      .cy    (cy_q),
      .dir   (dir[i]),
      .legal (legal[i])
    );

    assign in_ready[i] = room[i] & cap_q;
    assign push[i]     = in_valid[i] & in_ready[i];
    assign drop[i]     = hv[i] & ~legal[i];
  end

  // request matrix
  always_comb begin
    for (int o = 0; o < NUM_IN; o++) begin
      for (int i = 0; i < NUM_IN; i++) begin
        req[o][i] = hv[i] & legal[i] & (dir[i] == PIDX_W'(o));
      end
    end
  end

  // output side: one arbiter per output
  for (genvar o = 0; o < NUM_IN; o++) begin : g_out
    if (o == LOC_IDX) begin : g_loc
      assign ordy[o] = 1'b1;
    end else begin : g_link
      assign ordy[o] = out_ready[o];
    end

    msr_rr_arb #(.N(NUM_IN)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req[o]),
      .ready (ordy[o]),
      .valid (ovalid[o]),
      .gidx  (gidx[o]),
      .xfer  (oxfer[o])
    );

    assign sel[o] = head[gidx[o]];
  end

  for (genvar o = 0; o < NUM_LINK; o++) begin : g_link_out
    assign out_valid[o] = ovalid[o];
    assign out_data[o]  = sel[o];
  end

  // dequeue: served by an output or discarded for a bad opcode
  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      pop[i] = drop[i];
      for (int o = 0; o < NUM_IN; o++) begin
        if (oxfer[o] && (gidx[o] == PIDX_W'(i))) pop[i] = 1'b1;
      end
    end
  end

  // local ejection straight into the data memory
  pkt_t lpkt;
  logic unused_local;
  assign lpkt         = sel[LOC_IDX];
  assign mem_we       = ovalid[LOC_IDX];
  assign mem_addr     = lpkt.waddr[MEM_AW-1:0];
  assign mem_wdata    = lpkt.data;
  assign mem_be       = lpkt.be;
  assign unused_local = ^{lpkt.op, lpkt.dx, lpkt.dy, lpkt.waddr[WADDR_W-1:MEM_AW]};

  always_comb begin
    cap_d = 1'b1;
    cx_d  = cap_q ? cx_q : my_x;
    cy_d  = cap_q ? cy_q : my_y;
    err_d = err_q | (|drop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= 1'b0;
      cx_q  <= '0;
      cy_q  <= '0;
      err_q <= 1'b0;
    end else begin
      cap_q <= cap_d;
      cx_q  <= cx_d;
      cy_q  <= cy_d;
      err_q <= err_d;
    end
  end

  assign err_flag = err_q;
endmodule

// File: rtl/msr_checker.sv
module msr_checker
  import msr_pkg::*;
(
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_LINK-1:0]            out_valid,
  input logic [NUM_LINK-1:0]            out_ready,
  input logic [NUM_LINK-1:0][PKT_W-1:0] out_data,
  input logic                           err_flag,
  input logic                           cap_q,
  input logic [COORD_W-1:0]             cx_q,
  input logic [COORD_W-1:0]             cy_q
);
  for (genvar o = 0; o < NUM_LINK; o++) begin : g_hold
    AST_LINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && !out_ready[o]) |=> (out_valid[o] && $stable(out_data[o]))); // R9
  end

  AST_EAST_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[2] |-> (out_data[2][DX_LSB +: COORD_W] > cx_q)); // R2

  AST_WEST_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[3] |-> (out_data[3][DX_LSB +: COORD_W] < cx_q)); // R2

  AST_NORTH_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[0] |-> ((out_data[0][DX_LSB +: COORD_W] == cx_q) &&
                      (out_data[0][DY_LSB +: COORD_W] < cy_q))); // R3

  AST_SOUTH_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[1] |-> ((out_data[1][DX_LSB +: COORD_W] == cx_q) &&
                      (out_data[1][DY_LSB +: COORD_W] > cy_q))); // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R1

  AST_COORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    cap_q |=> ($stable(cx_q) && $stable(cy_q))); // R8
endmodule

bind mesh_store_router msr_checker u_msr_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .err_flag  (err_flag),
  .cap_q     (cap_q),
  .cx_q      (cx_q),
  .cy_q      (cy_q)
);

// File: tb/mesh_store_router_bench.sv
module mesh_store_router_bench;
  import msr_pkg::*;

  localparam int PN = 0, PS = 1, PE = 2, PWST = 3, PL = 4;

  logic                           clk = 1'b0;
  logic                           rst_n;
  logic [COORD_W-1:0]             my_x, my_y;
  logic [NUM_IN-1:0]              in_valid;
  logic [NUM_IN-1:0]              in_ready;
  logic [NUM_IN-1:0][PKT_W-1:0]   in_data;
  logic [NUM_LINK-1:0]            out_valid;
  logic [NUM_LINK-1:0]            out_ready;
  logic [NUM_LINK-1:0][PKT_W-1:0] out_data;
  logic                           mem_we;
  logic [9:0]                     mem_addr;
  logic [31:0]                    mem_wdata;
  logic [3:0]                     mem_be;
  logic                           err_flag;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  mesh_store_router u_mesh_store_router (
    .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .err_flag(err_flag)
  );

  function automatic logic [PKT_W-1:0] mk(input logic [3:0] op, input logic [3:0] be,
                                           input logic [4:0] dx, input logic [4:0] dy,
                                           input logic [29:0] wa, input logic [31:0] d);
    return {op, be, dx, dy, wa, d};
  endfunction

  task automatic chk(input string tag, input logic [PKT_W-1:0] act, input logic [PKT_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_one(input int port, input logic [PKT_W-1:0] p);
    in_valid[port] = 1'b1;
    in_data[port]  = p;
    @(negedge clk);
    in_valid[port] = 1'b0;
  endtask

  task automatic t_reset;
    chk("R8 reset out_valid", PKT_W'(out_valid), '0);
    chk("R4 reset mem_we", PKT_W'(mem_we), '0);
    chk("R1 reset err_flag", PKT_W'(err_flag), '0);
    @(negedge clk);
    rst_n = 1'b1;
    #0;
    chk("R8 ready low before capture", PKT_W'(in_ready), '0);
    @(negedge clk);
    chk("R8 ready high after capture", PKT_W'(in_ready), PKT_W'(5'h1F));
  endtask

  task automatic route_case(input string tag, input logic [4:0] dx, input logic [4:0] dy,
                            input int exp_port, input logic [31:0] d);
    logic [PKT_W-1:0] p;
    p = mk(OP_STORE, 4'hF, dx, dy, 30'h10, d);
    push_one(PL, p);
    chk({tag, " valid"}, PKT_W'(out_valid), PKT_W'(4'b1 << exp_port));
    chk({tag, " data"}, out_data[exp_port], p);
    @(negedge clk);
    chk({tag, " drained"}, PKT_W'(out_valid), '0);
  endtask

  task automatic t_route_x;
    out_ready = 4'hF;
    route_case("R2 east far Y", 5'd3, 5'd0, PE, 32'hE0E0_0001);
    route_case("R2 west far Y", 5'd0, 5'd5, PWST, 32'hA0A0_0002);
  endtask

  task automatic t_route_y;
    route_case("R3 north", 5'd2, 5'd0, PN, 32'h1111_0003);
    route_case("R3 south", 5'd2, 5'd3, PS, 32'h2222_0004);
    route_case("R3 south io row", 5'd2, 5'd4, PS, 32'h3333_0005);
  endtask

  task automatic t_local;
    logic [PKT_W-1:0] p;
    p = mk(OP_STORE, 4'b0101, 5'd2, 5'd2, 30'h2_3A7, 32'hCAFE_F00D);
    push_one(PL, p);
    chk("R4 local we", PKT_W'(mem_we), PKT_W'(1'b1));
    chk("R4 local addr", PKT_W'(mem_addr), PKT_W'(10'h3A7));
    chk("R4 local data", PKT_W'(mem_wdata), PKT_W'(32'hCAFE_F00D));
    chk("R4 local be", PKT_W'(mem_be), PKT_W'(4'b0101));
    chk("R4 local no link", PKT_W'(out_valid), '0);
    @(negedge clk);
    chk("R4 local one write", PKT_W'(mem_we), '0);
  endtask

  task automatic t_concurrent;
    in_valid[PN]   = 1'b1;
    in_data[PN]    = mk(4'h0, 4'hF, 5'd3, 5'd2, 30'h5, 32'hBAD0_BAD0);
    in_valid[PWST] = 1'b1;
    in_data[PWST]  = mk(OP_STORE, 4'b1000, 5'd2, 5'd2, 30'h12, 32'h7777_8888);
    @(negedge clk);
    in_valid = '0;
    chk("R4 concurrent we", PKT_W'(mem_we), PKT_W'(1'b1));
    chk("R4 concurrent data", PKT_W'(mem_wdata), PKT_W'(32'h7777_8888));
    chk("R1 bad op not routed", PKT_W'(out_valid), '0);
    chk("R1 err not yet", PKT_W'(err_flag), '0);
    @(negedge clk);
    chk("R1 err set", PKT_W'(err_flag), PKT_W'(1'b1));
    chk("R1 bad op gone", PKT_W'(out_valid), '0);
  endtask

  task automatic t_sticky;
    route_case("R1 traffic after err", 5'd4, 5'd2, PE, 32'h5555_0006);
    @(negedge clk);
    chk("R1 err sticky", PKT_W'(err_flag), PKT_W'(1'b1));
  endtask

  task automatic t_rr;
    logic [PKT_W-1:0] n1, n2, w1, w2;
    n1 = mk(OP_STORE, 4'hF, 5'd3, 5'd2, 30'h1, 32'h0000_00A1);
    n2 = mk(OP_STORE, 4'hF, 5'd3, 5'd2, 30'h2, 32'h0000_00A2);
    w1 = mk(OP_STORE, 4'hF, 5'd3, 5'd2, 30'h3, 32'h0000_00B1);
    w2 = mk(OP_STORE, 4'hF, 5'd3, 5'd2, 30'h4, 32'h0000_00B2);
    out_ready[PE] = 1'b0;
    in_valid[PN] = 1'b1; in_data[PN] = n1;
    in_valid[PWST] = 1'b1; in_data[PWST] = w1;
    @(negedge clk);
    in_data[PN] = n2; in_data[PWST] = w2;
    @(negedge clk);
    in_valid = '0;
    chk("R5 north full ready low", PKT_W'(in_ready[PN]), '0);
    chk("R9 stalled east held", out_data[PE], n1);
    out_ready[PE] = 1'b1;
    chk("R6 rr first north", out_data[PE], n1);
    @(negedge clk);
    chk("R6 rr then west", out_data[PE], w1);
    @(negedge clk);
    chk("R6 rr back north", out_data[PE], n2);
    @(negedge clk);
    chk("R6 rr west again", out_data[PE], w2);
    @(negedge clk);
    chk("R6 rr drained", PKT_W'(out_valid), '0);
  endtask

  task automatic t_order;
    logic [PKT_W-1:0] p1, p2, p3;
    p1 = mk(OP_STORE, 4'hF, 5'd1, 5'd2, 30'h21, 32'h0000_0C01);
    p2 = mk(OP_STORE, 4'hF, 5'd1, 5'd2, 30'h22, 32'h0000_0C02);
    p3 = mk(OP_STORE, 4'hF, 5'd1, 5'd2, 30'h23, 32'h0000_0C03);
    out_ready[PWST] = 1'b0;
    in_valid[PL] = 1'b1; in_data[PL] = p1;
    @(negedge clk);
    in_data[PL] = p2;
    @(negedge clk);
    chk("R5 local full ready low", PKT_W'(in_ready[PL]), '0);
    in_data[PL] = p3;
    @(negedge clk);
    in_valid = '0;
    out_ready[PWST] = 1'b1;
    chk("R7 order first", out_data[PWST], p1);
    @(negedge clk);
    chk("R7 order second", out_data[PWST], p2);
    @(negedge clk);
    chk("R5 third not accepted", PKT_W'(out_valid), '0);
  endtask

  task automatic t_coord;
    my_x = 5'd0;
    my_y = 5'd0;
    @(negedge clk);
    route_case("R8 pins ignored west", 5'd1, 5'd2, PWST, 32'hD00D_0007);
    route_case("R8 pins ignored not local", 5'd0, 5'd0, PWST, 32'hD00D_0008);
  endtask

  initial begin
    rst_n     = 1'b0;
    my_x      = 5'd2;
    my_y      = 5'd2;
    in_valid  = '0;
    in_data   = '0;
    out_ready = 4'hF;
    repeat (3) @(negedge clk);
    t_reset;
    t_route_x;
    t_route_y;
    t_local;
    t_concurrent;
    t_sticky;
    t_rr;
    t_order;
    t_coord;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule